// File: doc/BRIEF.md
# SD Four-Line Data Streamer

This block moves 32-bit host words across the four data lines of an SD card bus, in both directions, and handles the checking around each block. On a write, a host word is broken into eight nibbles and driven onto the lines, one nibble per card clock. When a full block has gone out, the block appends a 16-bit CRC for each line and an end nibble. On a read, the same nibble order is used to build words from the lines, and the CRC that arrives after the block is compared against one computed locally.

After a block write the card answers with a three-bit CRC status token on line 0 and then holds line 0 low while it is busy. The block can wait for both of these on its own, either because the host asks for it or, in write-multiple mode, right after every block. It flags a bad token or a bad read CRC in a sticky CRC-error bit. It flags a wait that runs too long in a sticky timeout bit.

The card clock is given as a per-cycle enable `sdClk`: each system cycle with `sdClk` high is one card clock. Outgoing nibbles are valid in that same cycle. Incoming nibbles are sampled at the rising system edge that ends that cycle. Issuing commands, initializing the card and choosing the clock rate are left to other logic.

Top module: `sd_dat_streamer`

## Requirements
- R1: After reset the block is ready, drives no lines (`datOe` low), gives no card clock, and both `crcErr` and `timeoutFlag` are 0.
- R2: A write strobe while idle starts a block. The block first emits one start nibble 0x0, then the word's eight nibbles in this order: bits 7:4, 3:0, 15:12, 11:8, 23:20, 19:16, 31:28, 27:24. Line n carries bit n of each nibble, there is one nibble per clock cycle, and `datOe` is high throughout.
- R3: While the host has not yet supplied the next word of a block, no card clock is given. After the last word of a block (`BLOCK_WORDS` words), each line sends its CRC16 MSB first, then the end nibble 0xF. The CRC uses polynomial x^16+x^12+x^5+1 and a zero start value, and is computed over that line's data bits only. The total is 1+8*BLOCK_WORDS+16+1 clocks with `datOe` high.
- R4: A wait strobe while idle starts the response wait. The block gives clocks until line 0 is sampled low (start bit). It then samples three bits on line 0, first to last: 0,1,0 is accepted and any other pattern sets `crcErr`. It gives one more clock for the end bit, then gives clocks while line 0 is low. It becomes ready again on the first clock in which line 0 is high.
- R5: With `wrMultEn` high, the response wait of R4 begins right after the end nibble of every written block, with no wait strobe. With it low, the block is ready right after the end nibble and gives no further clock.
- R6: A read strobe while idle gives clocks until line 0 is low (start bit). The block then assembles eight incoming nibbles into a word using the order of R2. It pulses `rdValid` for one cycle with the word on `rdData`, and each further word of the block is fetched by another read strobe.
- R7: After the last word of a read block, the block receives 16 CRC nibbles and one end nibble. It sets `crcErr` if any line's received CRC differs from the CRC16 of that line's received data.
- R8: With `rdMultEn` high, after a read block's end nibble the block keeps clocking while line 0 is low before it becomes ready. With it low, the block is ready at once.
- R9: If `TIMEOUT_CLKS` clocks of a start-bit wait or busy wait pass without the awaited level on line 0, `timeoutFlag` is set and the block returns to ready.
- R10: `crcErr` and `timeoutFlag` hold until `flagClr` is high.
- R11: Strobes given while `ready` is low have no effect on the line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wrStb | input | 1 | Host supplies a word to write |
| wrData | input | 32 | Word to write |
| rdStb | input | 1 | Host requests the next word to read |
| waitStb | input | 1 | Start the CRC-token and busy wait |
| wrMultEn | input | 1 | Automatic response wait after every written block |
| rdMultEn | input | 1 | Busy wait after every read block |
| flagClr | input | 1 | Clear the sticky flags |
| datIn | input | 4 | Data lines from the card |
| datOut | output | 4 | Data lines to the card |
| datOe | output | 1 | Drive enable for the data lines |
| sdClk | output | 1 | Card clock enable, one card clock per high cycle |
| ready | output | 1 | Block accepts the next host strobe |
| rdData | output | 32 | Last word read |
| rdValid | output | 1 | One-cycle pulse when `rdData` is complete |
| crcErr | output | 1 | Sticky CRC or token error |
| timeoutFlag | output | 1 | Sticky timeout |

## Verification
Outgoing nibbles are due in the same cycle as their clock, so the card model in the bench captures `datOut` at the falling edge of every cycle that has `sdClk` and `datOe` high. It also feeds `datIn` at falling edges, so an incoming value is sampled at the next rising edge. `rdValid` and both flags are due one cycle after the clock that decides them, and the bench reads them at the following falling edge. Pulse counts and queue contents are read only one falling edge after `ready` returns, so the card model has counted the final clock before any check uses it.

// File: rtl/sd_stream_pkg.sv
package sd_stream_pkg;

  localparam int SD_LANES     = 4;
  localparam int SD_WORD_W    = 32;
  localparam int SD_NIB_CNT   = SD_WORD_W / SD_LANES;
  localparam int SD_NIB_IDX_W = $clog2(SD_NIB_CNT);
  localparam int SD_OFF_W     = $clog2(SD_WORD_W);
  localparam int SD_CRC_W     = 16;
  localparam int SD_CRC_CNT_W = $clog2(SD_CRC_W);
  localparam logic [SD_CRC_W-1:0] SD_CRC_POLY = 16'h1021;

  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WDATA, S_WHOLD, S_WCRC, S_WEND,
    S_TWAIT, S_TBITS, S_TEND, S_BUSY,
    S_RSTART, S_RDATA, S_RHOLD, S_RCRC, S_REND
  } state_e;

  typedef enum logic [1:0] {
    OUT_LOW, OUT_DATA, OUT_CRC, OUT_HIGH
  } out_sel_e;

  typedef struct packed {
    logic                    loadWord;
    logic                    crcClr;
    logic                    crcFeed;
    logic                    crcDrain;
    logic                    readDir;
    logic                    storeNib;
    logic                    tokShift;
    logic                    cmpClr;
    logic [SD_NIB_IDX_W-1:0] nibIdx;
    out_sel_e                outSel;
  } dp_ctrl_t;

endpackage

// File: rtl/sd_crc16_lane.sv
module sd_crc16_lane
  import sd_stream_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic feed,
  input  logic drain,
  input  logic bitIn,
  output logic msb
);

  logic [SD_CRC_W-1:0] crcReg;
  logic [SD_CRC_W-1:0] crcNext;

  always_comb begin
    crcNext = {crcReg[SD_CRC_W-2:0], 1'b0} ^
              ({SD_CRC_W{bitIn ^ crcReg[SD_CRC_W-1]}} & SD_CRC_POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crcReg <= '0;
    else if (clr)   crcReg <= '0;
    else if (feed)  crcReg <= crcNext;
    else if (drain) crcReg <= {crcReg[SD_CRC_W-2:0], 1'b0};
  end

  assign msb = crcReg[SD_CRC_W-1];

endmodule

// File: rtl/sd_stream_dp.sv
module sd_stream_dp
  import sd_stream_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  dp_ctrl_t             ctl,
  input  logic [SD_WORD_W-1:0] wrData,
  input  logic [SD_LANES-1:0]  datIn,
  output logic [SD_LANES-1:0]  datOut,
  output logic [SD_WORD_W-1:0] rdWord,
  output logic                 crcBad,
  output logic                 tokOk
);

  logic [SD_WORD_W-1:0] wrWord;
  logic [SD_OFF_W-1:0]  bitOff;
  logic [SD_LANES-1:0]  txNib;
  logic [SD_LANES-1:0]  crcIn;
  logic [SD_LANES-1:0]  crcMsb;
  logic                 crcMismatch;
  logic [1:0]           tokReg;

  // Byte order low to high; within a byte, upper nibble first.
  always_comb begin
    bitOff = SD_OFF_W'({ctl.nibIdx[SD_NIB_IDX_W-1:1], 3'b000}) +
             (ctl.nibIdx[0] ? SD_OFF_W'(0) : SD_OFF_W'(SD_LANES));
    txNib  = wrWord[bitOff +: SD_LANES];
    crcIn  = ctl.readDir ? datIn : txNib;
  end

  always_comb begin
    case (ctl.outSel)
      OUT_LOW:  datOut = '0;
      OUT_DATA: datOut = txNib;
      OUT_CRC:  datOut = crcMsb;
      default:  datOut = '1;
    endcase
  end

  for (genvar l = 0; l < SD_LANES; l++) begin : g_lane
    sd_crc16_lane u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl.crcClr),
      .feed  (ctl.crcFeed),
      .drain (ctl.crcDrain),
      .bitIn (crcIn[l]),
      .msb   (crcMsb[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrWord      <= '0;
      rdWord      <= '0;
      crcMismatch <= 1'b0;
      tokReg      <= '0;
    end else begin
      if (ctl.loadWord) wrWord <= wrData;
      if (ctl.storeNib) rdWord[bitOff +: SD_LANES] <= datIn;
      if (ctl.cmpClr)
        crcMismatch <= 1'b0;
      else if (ctl.crcDrain && ctl.readDir && (datIn != crcMsb))
        crcMismatch <= 1'b1;
      if (ctl.tokShift) tokReg <= {tokReg[0], datIn[0]};
    end
  end

  assign crcBad = crcMismatch;
  assign tokOk  = ({tokReg, datIn[0]} == 3'b010);

  // R7: a recorded mismatch survives until the next read block clears it
  a_r7_mismatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (crcMismatch && !ctl.cmpClr) |=> crcMismatch);

endmodule

// File: rtl/sd_stream_ctrl.sv
module sd_stream_ctrl
  import sd_stream_pkg::*;
#(
  parameter int BLOCK_WORDS  = 128,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrStb,
  input  logic     rdStb,
  input  logic     waitStb,
  input  logic     wrMultEn,
  input  logic     rdMultEn,
  input  logic     flagClr,
  input  logic     dat0,
  input  logic     crcBad,
  input  logic     tokOk,
  output dp_ctrl_t ctl,
  output logic     sdClk,
  output logic     datOe,
  output logic     ready,
  output logic     rdValid,
  output logic     crcErr,
  output logic     timeoutFlag
);

  localparam int WC_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam int TM_W = (TIMEOUT_CLKS > 1) ? $clog2(TIMEOUT_CLKS) : 1;

  state_e                  state;
  logic [SD_NIB_IDX_W-1:0] nibCnt;
  logic [SD_CRC_CNT_W-1:0] crcCnt;
  logic [WC_W-1:0]         wordCnt;
  logic [TM_W-1:0]         tmoCnt;
  logic [1:0]              tokCnt;
  logic                    lastNib, lastWord, lastCrc, tmoHit;

  assign lastNib  = (nibCnt == SD_NIB_IDX_W'(SD_NIB_CNT - 1));
  assign lastWord = (wordCnt == WC_W'(BLOCK_WORDS - 1));
  assign lastCrc  = (crcCnt == SD_CRC_CNT_W'(SD_CRC_W - 1));
  assign tmoHit   = (tmoCnt == TM_W'(TIMEOUT_CLKS - 1));

  always_comb begin
    sdClk = 1'b0;
    datOe = 1'b0;
    ready = 1'b0;
    case (state)
      S_IDLE, S_WHOLD, S_RHOLD: ready = 1'b1;
      S_WSTART, S_WDATA, S_WCRC, S_WEND: begin
        sdClk = 1'b1;
        datOe = 1'b1;
      end
      default: sdClk = 1'b1;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.nibIdx = nibCnt;
    ctl.outSel = OUT_HIGH;
    case (state)
      S_IDLE: begin
        if (wrStb) begin
          ctl.loadWord = 1'b1;
          ctl.crcClr   = 1'b1;
        end else if (rdStb) begin
          ctl.crcClr = 1'b1;
          ctl.cmpClr = 1'b1;
        end
      end
      S_WSTART: ctl.outSel = OUT_LOW;
      S_WDATA: begin
        ctl.outSel  = OUT_DATA;
        ctl.crcFeed = 1'b1;
      end
      S_WHOLD:  ctl.loadWord = wrStb;
      S_WCRC: begin
        ctl.outSel   = OUT_CRC;
        ctl.crcDrain = 1'b1;
      end
      S_TBITS:  ctl.tokShift = 1'b1;
      S_RDATA: begin
        ctl.readDir  = 1'b1;
        ctl.crcFeed  = 1'b1;
        ctl.storeNib = 1'b1;
      end
      S_RCRC: begin
        ctl.readDir  = 1'b1;
        ctl.crcDrain = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      nibCnt      <= '0;
      crcCnt      <= '0;
      wordCnt     <= '0;
      tmoCnt      <= '0;
      tokCnt      <= '0;
      rdValid     <= 1'b0;
      crcErr      <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (flagClr) begin
        crcErr      <= 1'b0;
        timeoutFlag <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          nibCnt  <= '0;
          wordCnt <= '0;
          tmoCnt  <= '0;
          if (wrStb)        state <= S_WSTART;
          else if (rdStb)   state <= S_RSTART;
          else if (waitStb) state <= S_TWAIT;
        end
        S_WSTART: state <= S_WDATA;
        S_WDATA: begin
          nibCnt <= nibCnt + 1'b1;
          if (lastNib) begin
            nibCnt <= '0;
            if (lastWord) begin
              crcCnt <= '0;
              state  <= S_WCRC;
            end else begin
              wordCnt <= wordCnt + 1'b1;
              state   <= S_WHOLD;
            end
          end
        end
        S_WHOLD: if (wrStb) state <= S_WDATA;
        S_WCRC: begin
          crcCnt <= crcCnt + 1'b1;
          if (lastCrc) state <= S_WEND;
        end
        S_WEND: begin
          tmoCnt <= '0;
          state  <= wrMultEn ? S_TWAIT : S_IDLE;
        end
        S_TWAIT: begin
          if (!dat0) begin
            tokCnt <= '0;
            state  <= S_TBITS;
          end else if (tmoHit) begin
            timeoutFlag <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
          end
        end
        S_TBITS: begin
          tokCnt <= tokCnt + 1'b1;
          if (tokCnt == 2'd2) begin
            if (!tokOk) crcErr <= 1'b1;
            state <= S_TEND;
          end
        end
        S_TEND: begin
          tmoCnt <= '0;
          state  <= S_BUSY;
        end
        S_BUSY: begin
          if (dat0) begin
            state <= S_IDLE;
          end else if (tmoHit) begin
            timeoutFlag <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
          end
        end
        S_RSTART: begin
          if (!dat0) begin
            nibCnt <= '0;
            state  <= S_RDATA;
          end else if (tmoHit) begin
            timeoutFlag <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
          end
        end
        S_RDATA: begin
          nibCnt <= nibCnt + 1'b1;
          if (lastNib) begin
            nibCnt  <= '0;
            rdValid <= 1'b1;
            if (lastWord) begin
              crcCnt <= '0;
              state  <= S_RCRC;
            end else begin
              wordCnt <= wordCnt + 1'b1;
              state   <= S_RHOLD;
            end
          end
        end
        S_RHOLD: if (rdStb) state <= S_RDATA;
        S_RCRC: begin
          crcCnt <= crcCnt + 1'b1;
          if (lastCrc) state <= S_REND;
        end
        S_REND: begin
          if (crcBad) crcErr <= 1'b1;
          tmoCnt <= '0;
          state  <= rdMultEn ? S_BUSY : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: write-multiple enters the token wait straight after the end nibble
  a_r5_auto_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WEND && wrMultEn) |=> (state == S_TWAIT));

  // R6: the word-complete strobe lasts a single cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid);

  // R9: a timeout always lands the machine back in idle
  a_r9_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutFlag) |-> (state == S_IDLE));

  // R10: flags are sticky until cleared
  a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeoutFlag && !flagClr) |=> timeoutFlag);
  a_r10_crc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (crcErr && !flagClr) |=> crcErr);

  // R11: an active data phase is never cut short by a host strobe
  a_r11_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA) |=> (state == S_WDATA || state == S_WHOLD || state == S_WCRC));

endmodule

// File: rtl/sd_dat_streamer.sv
module sd_dat_streamer
  import sd_stream_pkg::*;
#(
  parameter int BLOCK_WORDS  = 128,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrStb,
  input  logic [SD_WORD_W-1:0] wrData,
  input  logic                 rdStb,
  input  logic                 waitStb,
  input  logic                 wrMultEn,
  input  logic                 rdMultEn,
  input  logic                 flagClr,
  input  logic [SD_LANES-1:0]  datIn,
  output logic [SD_LANES-1:0]  datOut,
  output logic                 datOe,
  output logic                 sdClk,
  output logic                 ready,
  output logic [SD_WORD_W-1:0] rdData,
  output logic                 rdValid,
  output logic                 crcErr,
  output logic                 timeoutFlag
);

  dp_ctrl_t ctl;
  logic     crcBad;
  logic     tokOk;

  sd_stream_ctrl #(
    .BLOCK_WORDS  (BLOCK_WORDS),
    .TIMEOUT_CLKS (TIMEOUT_CLKS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrStb       (wrStb),
    .rdStb       (rdStb),
    .waitStb     (waitStb),
    .wrMultEn    (wrMultEn),
    .rdMultEn    (rdMultEn),
    .flagClr     (flagClr),
    .dat0        (datIn[0]),
    .crcBad      (crcBad),
    .tokOk       (tokOk),
    .ctl         (ctl),
    .sdClk       (sdClk),
    .datOe       (datOe),
    .ready       (ready),
    .rdValid     (rdValid),
    .crcErr      (crcErr),
    .timeoutFlag (timeoutFlag)
  );

  sd_stream_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .wrData (wrData),
    .datIn  (datIn),
    .datOut (datOut),
    .rdWord (rdData),
    .crcBad (crcBad),
    .tokOk  (tokOk)
  );

  // R2: a write strobe in idle is followed by the all-low start nibble
  a_r2_start_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !datOe && !sdClk && wrStb && !(u_ctrl.state inside {S_WHOLD, S_RHOLD}))
      |=> (datOe && sdClk && datOut == '0));

endmodule

// File: tb/sd_dat_streamer_test.sv
`timescale 1ns/1ps
module sd_dat_streamer_test;

  localparam int BW  = 4;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wrStb, rdStb, waitStb, wrMultEn, rdMultEn, flagClr;
  logic [31:0] wrData;
  logic [3:0]  datIn = 4'hF;
  logic [3:0]  datOut;
  logic        datOe, sdClk, ready, rdValid, crcErr, timeoutFlag;
  logic [31:0] rdData;

  int total = 0;
  int bad   = 0;

  logic [3:0] inQ[$];
  logic [3:0] outQ[$];
  int         inPulses = 0;
  logic       pullPrev = 1'b0;

  always #2.5 clk = ~clk;

  sd_dat_streamer #(.BLOCK_WORDS(BW), .TIMEOUT_CLKS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb),
    .waitStb(waitStb), .wrMultEn(wrMultEn), .rdMultEn(rdMultEn), .flagClr(flagClr),
    .datIn(datIn), .datOut(datOut), .datOe(datOe), .sdClk(sdClk), .ready(ready),
    .rdData(rdData), .rdValid(rdValid), .crcErr(crcErr), .timeoutFlag(timeoutFlag)
  );

  // Card model: consumes one response nibble per card clock with lines released,
  // records every driven nibble.
  always @(negedge clk) begin
    if (pullPrev) begin
      inPulses++;
      if (inQ.size() > 0) void'(inQ.pop_front());
    end
    datIn = (inQ.size() > 0) ? inQ[0] : 4'hF;
    if (sdClk && datOe) outQ.push_back(datOut);
    pullPrev = sdClk && !datOe && rst_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input logic [31:0] w, input int k);
    int off;
    off = (k / 2) * 8 + (((k % 2) == 0) ? 4 : 0);
    return w[off +: 4];
  endfunction

  function automatic logic [15:0] lane_crc(input logic [3:0] nibs[$], input int lane);
    logic [15:0] c;
    logic        fb;
    c = '0;
    foreach (nibs[i]) begin
      fb = nibs[i][lane] ^ c[15];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // Data nibbles of a block followed by the 16 CRC nibbles
  task automatic build(input logic [31:0] w[$], output logic [3:0] dn[$], output logic [3:0] cn[$]);
    logic [15:0] c [4];
    dn.delete(); cn.delete();
    foreach (w[i]) for (int k = 0; k < 8; k++) dn.push_back(nib_of(w[i], k));
    for (int l = 0; l < 4; l++) c[l] = lane_crc(dn, l);
    for (int b = 15; b >= 0; b--) cn.push_back({c[3][b], c[2][b], c[1][b], c[0][b]});
  endtask

  task automatic pulse(input int which, input logic [31:0] d);
    @(negedge clk);
    wrData = d;
    wrStb = (which == 0); rdStb = (which == 1); waitStb = (which == 2);
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0; waitStb = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    int n;
    n = 0;
    while (!ready && n < 4000) begin @(negedge clk); n++; end
    if (!ready) chk({tag, " ready"}, 32'(ready), 32'd1);
  endtask

  task automatic wait_valid(input string tag);
    int n;
    n = 0;
    while (!rdValid && n < 4000) begin @(negedge clk); n++; end
    chk({tag, " rdValid"}, 32'(rdValid), 32'd1);
  endtask

  task automatic push_token(input logic [2:0] pat, input int busyN);
    inQ.push_back(4'hF); inQ.push_back(4'hF); inQ.push_back(4'hE);
    for (int b = 2; b >= 0; b--) inQ.push_back({3'b111, pat[b]});
    inQ.push_back(4'hF);
    for (int i = 0; i < busyN; i++) inQ.push_back(4'hE);
    inQ.push_back(4'hF);
  endtask

  task automatic write_block(input logic [31:0] w[$], input bit poke, input string tag);
    logic [3:0] dn[$];
    logic [3:0] cn[$];
    logic [3:0] st[$];
    build(w, dn, cn);
    st.delete();
    st.push_back(4'h0);
    foreach (dn[i]) st.push_back(dn[i]);
    foreach (cn[i]) st.push_back(cn[i]);
    st.push_back(4'hF);
    outQ.delete();
    foreach (w[i]) begin
      pulse(0, w[i]);
      if (poke && i == 0) begin
        pulse(1, 32'h0);   // R11 read strobe while busy
        pulse(2, 32'h0);   // R11 wait strobe while busy
        pulse(0, 32'hFFFF_FFFF); // R11 write strobe while busy
      end
      wait_ready(tag);
    end
    @(negedge clk);
    chk({tag, " stream length"}, 32'(outQ.size()), 32'(st.size()));
    foreach (st[i])
      if (i < outQ.size()) chk($sformatf("%s nibble %0d", tag, i), 32'(outQ[i]), 32'(st[i]));
  endtask

  task automatic read_block(input logic [31:0] w[$], input bit corrupt, input string tag);
    logic [3:0] dn[$];
    logic [3:0] cn[$];
    build(w, dn, cn);
    if (corrupt) cn[3] = cn[3] ^ 4'h4;
    inQ.push_back(4'hF); inQ.push_back(4'hF); inQ.push_back(4'h0);
    foreach (dn[i]) inQ.push_back(dn[i]);
    foreach (cn[i]) inQ.push_back(cn[i]);
    inQ.push_back(4'hF);
    foreach (w[i]) begin
      pulse(1, 32'h0);
      wait_valid(tag);
      chk($sformatf("%s word %0d", tag, i), rdData, w[i]);
    end
  endtask

  initial begin
    logic [31:0] wa[$];
    logic [31:0] wb[$];
    logic [31:0] wc[$];
    rst_n = 1'b0; wrStb = 0; rdStb = 0; waitStb = 0;
    wrMultEn = 0; rdMultEn = 0; flagClr = 0; wrData = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(ready), 1);
    chk("R1 datOe", 32'(datOe), 0);
    chk("R1 sdClk", 32'(sdClk), 0);
    chk("R1 crcErr", 32'(crcErr), 0);
    chk("R1 timeoutFlag", 32'(timeoutFlag), 0);

    wa = '{32'h8421_F00D, 32'h0123_4567, 32'hDEAD_BEEF, 32'h0000_0001};
    wb = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A, 32'h1357_9BDF};
    wc = '{32'hCAFE_0042, 32'h7F00_00FE, 32'h3C3C_C3C3, 32'h8000_0000};

    // R2 R3 plain write block, R5 no automatic wait
    inPulses = 0;
    write_block(wa, 1'b0, "R2 R3 write");
    chk("R5 no auto wait pulses", 32'(inPulses), 0);

    // R4 accepted token with busy period
    inPulses = 0;
    push_token(3'b010, 5);
    pulse(2, 32'h0);
    wait_ready("R4 wait");
    @(negedge clk);
    chk("R4 token pulses", 32'(inPulses), 13);
    chk("R4 token ok crcErr", 32'(crcErr), 0);
    chk("R4 queue drained", 32'(inQ.size()), 0);

    // R4 rejected token
    inPulses = 0;
    push_token(3'b101, 2);
    pulse(2, 32'h0);
    wait_ready("R4 bad");
    @(negedge clk);
    chk("R4 bad token crcErr", 32'(crcErr), 1);
    chk("R4 bad token pulses", 32'(inPulses), 10);
    repeat (10) @(negedge clk);
    chk("R10 crcErr sticky", 32'(crcErr), 1);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0; @(negedge clk);
    chk("R10 crcErr cleared", 32'(crcErr), 0);

    // R5 write-multiple: wait happens on its own
    wrMultEn = 1'b1;
    inPulses = 0;
    push_token(3'b010, 5);
    write_block(wb, 1'b0, "R5 multi write");
    chk("R5 auto wait pulses", 32'(inPulses), 13);
    chk("R5 crcErr", 32'(crcErr), 0);
    wrMultEn = 1'b0;

    // R11 strobes while busy are ignored
    inPulses = 0;
    write_block(wc, 1'b1, "R11 ignore");
    chk("R11 no extra response clocks", 32'(inPulses), 0);

    // R6 R7 good read block, R8 off
    inPulses = 0;
    read_block(wa, 1'b0, "R6 read");
    wait_ready("R7 read");
    @(negedge clk);
    chk("R7 good crc", 32'(crcErr), 0);
    chk("R8 read pulses", 32'(inPulses), 3 + 8 * BW + 17);
    chk("R7 queue drained", 32'(inQ.size()), 0);

    // R7 corrupted CRC, R8 busy after read
    rdMultEn = 1'b1;
    inPulses = 0;
    read_block(wb, 1'b1, "R7 bad read");
    for (int i = 0; i < 3; i++) inQ.push_back(4'hE);
    inQ.push_back(4'hF);
    wait_ready("R8 busy");
    @(negedge clk);
    chk("R7 crc mismatch flag", 32'(crcErr), 1);
    chk("R8 busy pulses", 32'(inPulses), 3 + 8 * BW + 17 + 4);
    chk("R8 queue drained", 32'(inQ.size()), 0);
    rdMultEn = 1'b0;
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;

    // R9 timeout waiting for token start
    inPulses = 0;
    pulse(2, 32'h0);
    wait_ready("R9 token");
    @(negedge clk);
    chk("R9 token timeout flag", 32'(timeoutFlag), 1);
    chk("R9 token timeout pulses", 32'(inPulses), TMO);
    chk("R9 crcErr untouched", 32'(crcErr), 0);
    repeat (5) @(negedge clk);
    chk("R10 timeout sticky", 32'(timeoutFlag), 1);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0; @(negedge clk);
    chk("R10 timeout cleared", 32'(timeoutFlag), 0);

    // R9 timeout in busy wait
    inPulses = 0;
    inQ.push_back(4'hE);
    inQ.push_back(4'hE); inQ.push_back(4'hF); inQ.push_back(4'hE);
    inQ.push_back(4'hF);
    for (int i = 0; i < TMO + 20; i++) inQ.push_back(4'hE);
    pulse(2, 32'h0);
    wait_ready("R9 busy");
    @(negedge clk);
    chk("R9 busy timeout flag", 32'(timeoutFlag), 1);
    chk("R9 busy timeout pulses", 32'(inPulses), 5 + TMO);
    inQ.delete();
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;

    // R9 timeout waiting for read start bit
    inPulses = 0;
    pulse(1, 32'h0);
    wait_ready("R9 read");
    @(negedge clk);
    chk("R9 read timeout flag", 32'(timeoutFlag), 1);
    chk("R9 read timeout pulses", 32'(inPulses), TMO);
    chk("R9 read no word", 32'(rdValid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule